// File: doc/BRIEF.md
# Bit-Selected Reset PWM Generator

This block produces one pulse-width-modulated output from an 8-bit counter that advances only on a slow reference tick, nominally 32 kHz, delivered as a single-cycle clock enable. The period is not held in a register. A 2-bit prescaler picks which counter bit, when reached, clears the counter. Prescaler p gives a period of 2^(7-p) ticks, so the four settings give 128, 64, 32 and 16 ticks. A 7-bit duty value is compared with the counter bits below the selected reset bit, and the output is high while those bits are below the duty value.

Software reaches two byte-wide registers over a small synchronous register bus. Address 0 is the control register: bit 7 enables the generator and bits [1:0] hold the prescaler. Address 1 is the duty register, bits [6:0]. Settings take effect immediately. Writing a new prescaler does not restart the counter, and a new duty value is used from the next compare, not from the next period boundary. Because the duty field is 7 bits wide, prescaler 0 cannot reach a 100% duty cycle.

Top module: `bitreset_pwm`

## Requirements
- R1: A synchronous active-high reset clears the control register, the duty register, the counter and the read data, so the output is low and both registers read 0x00.
- R2: Reads return stored contents one clock after the read strobe. Control reads as {enable, 5'b0, prescaler[1:0]} and duty reads as {1'b0, duty[6:0]}. Unused bits ignore writes and read zero. Addresses 2 and 3 read 0x00 and ignore writes.
- R3: While the enable bit (control bit 7) is 0, the output is low and the counter is held at zero. After enabling, the first period starts at count 0.
- R4: With prescaler p and duty d below the period, the output repeats every 2^(7-p) ticks. It is high during the first d ticks of each period and low for the rest. A duty of 0 gives a constant low.
- R5: A duty value equal to or larger than the current period 2^(7-p) drives the output constantly high.
- R6: With prescaler 0 and duty 127, the output is low for exactly one tick in every 128.
- R7: Writing a new prescaler does not clear the counter. Counting continues from its current value until the newly selected reset bit is reached, and the counter then returns to zero.
- R8: A new duty value affects the output in the clock cycle after the write, in the middle of a period.
- R9: The counter advances only in cycles where tick is high. Without ticks, the output holds its level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Counter advance enable, one cycle per reference tick |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, valid the cycle after rd_en |
| pwm_out | output | 1 | PWM output |

## Verification
The hardest state to reach from the ports is a counter that still holds high bits left over from a longer period after the prescaler is shortened. This state exists only because the counter is not cleared on a prescaler change, and software cannot read the counter. To reach it, the stimulus runs with prescaler 0 to a known count of 40, then switches to prescaler 3. It then checks the output level against the residual low bits, and afterwards checks the count at which the counter wraps. The result differs from what a counter restarted at zero would produce.

// File: rtl/bitreset_pwm_pkg.sv
package bitreset_pwm_pkg;

    localparam int CNT_W  = 8;
    localparam int PRE_W  = 2;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;
    localparam int DUTY_W = CNT_W - 1;
    localparam int EN_BIT = DATA_W - 1;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_DUTY = ADDR_W'(1);

    typedef struct packed {
        logic             enable;
        logic [PRE_W-1:0] presc;
    } ctrl_t;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [DUTY_W-1:0] duty;
    } cfg_t;

    // Index of the counter bit that clears the counter for prescaler p.
    function automatic int wrap_bit(input logic [PRE_W-1:0] p);
        return CNT_W - 1 - int'(p);
    endfunction

    // Number of ticks in one period for prescaler p.
    function automatic logic [CNT_W-1:0] period_len(input logic [PRE_W-1:0] p);
        return CNT_W'(1) << wrap_bit(p);
    endfunction

    // Mask of the counter bits that take part in the duty compare.
    function automatic logic [CNT_W-1:0] active_mask(input logic [PRE_W-1:0] p);
        return period_len(p) - CNT_W'(1);
    endfunction

endpackage

// File: rtl/bitreset_pwm_regs.sv
module bitreset_pwm_regs
    import bitreset_pwm_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output cfg_t          cfg
);

    cfg_t          cfg_q;
    logic [DW-1:0] rd_mux;
    logic [DW-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            case (addr)
                AW'(ADDR_CTRL): begin
                    cfg_q.ctrl.enable <= wr_data[EN_BIT];
                    cfg_q.ctrl.presc  <= wr_data[PRE_W-1:0];
                end
                AW'(ADDR_DUTY): cfg_q.duty <= wr_data[DUTY_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_mux = '0;
        case (addr)
            AW'(ADDR_CTRL): begin
                rd_mux[EN_BIT]      = cfg_q.ctrl.enable;
                rd_mux[PRE_W-1:0]   = cfg_q.ctrl.presc;
            end
            AW'(ADDR_DUTY): rd_mux[DUTY_W-1:0] = cfg_q.duty;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_q <= '0;
        else if (rd_en) rd_q <= rd_mux;
    end

    assign rd_data = rd_q;
    assign cfg     = cfg_q;

    AST_CTRL_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_en) && $past(addr) == AW'(ADDR_CTRL)) |-> (rd_data[EN_BIT-1:PRE_W] == '0)); // R2
    AST_DUTY_MSB_ZERO: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_en) && $past(addr) == AW'(ADDR_DUTY)) |-> (rd_data[DW-1] == 1'b0)); // R2
    AST_SPARE_ADDR_ZERO: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_en) && $past(addr) > AW'(ADDR_DUTY)) |-> (rd_data == '0)); // R2

endmodule

// File: rtl/bitreset_pwm_counter.sv
module bitreset_pwm_counter
    import bitreset_pwm_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int PW = PRE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          enable,
    input  logic [PW-1:0] presc,
    output logic [CW-1:0] count
);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_inc;
    logic          wrap;

    assign cnt_inc = cnt_q + CW'(1);

    // The selected reset bit of the incremented value returns the count to zero.
    always_comb begin
        wrap = 1'b0;
        for (int p = 0; p < (1 << PW); p++) begin
            if (presc == PW'(p)) wrap = cnt_inc[CW-1-p];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) cnt_q <= '0;
        else if (tick)      cnt_q <= wrap ? '0 : cnt_inc;
    end

    assign count = cnt_q;

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (count == '0)); // R3
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (enable && !tick) |=> (count == $past(count))); // R9
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (enable && tick && $past(enable)) |=> (count == '0 || count == $past(count) + CW'(1))); // R7

endmodule

// File: rtl/bitreset_pwm_compare.sv
module bitreset_pwm_compare
    import bitreset_pwm_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int PW = PRE_W,
    parameter int DUW = DUTY_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [CW-1:0]  count,
    input  logic           enable,
    input  logic [PW-1:0]  presc,
    input  logic [DUW-1:0] duty,
    output logic           pwm
);

    logic [CW-1:0] active;
    logic [CW-1:0] duty_ext;

    assign active   = count & active_mask(presc);
    assign duty_ext = CW'(duty);
    assign pwm      = enable && (active < duty_ext);

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
        !enable |-> !pwm); // R3
    AST_FULL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (enable && duty_ext >= period_len(presc)) |-> pwm); // R5
    AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (rst)
        (duty == '0) |-> !pwm); // R4

endmodule

// File: rtl/bitreset_pwm.sv
module bitreset_pwm
    import bitreset_pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              pwm_out
);

    cfg_t             cfg;
    logic [CNT_W-1:0] count;

    bitreset_pwm_regs #(.AW(ADDR_W), .DW(DATA_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .cfg     (cfg)
    );

    bitreset_pwm_counter #(.CW(CNT_W), .PW(PRE_W)) u_counter (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .enable (cfg.ctrl.enable),
        .presc  (cfg.ctrl.presc),
        .count  (count)
    );

    bitreset_pwm_compare #(.CW(CNT_W), .PW(PRE_W), .DUW(DUTY_W)) u_compare (
        .clk    (clk),
        .rst    (rst),
        .count  (count),
        .enable (cfg.ctrl.enable),
        .presc  (cfg.ctrl.presc),
        .duty   (cfg.duty),
        .pwm    (pwm_out)
    );

    AST_RESET_LOW: assert property (@(posedge clk)
        $past(rst) |-> !pwm_out); // R1
    AST_P0_NOT_FULL: assert property (@(posedge clk) disable iff (rst)
        (cfg.ctrl.enable && cfg.ctrl.presc == '0 && count == CNT_W'(127)) |-> !pwm_out); // R6

endmodule

// File: tb/bitreset_pwm_test.sv
`timescale 1ns/1ps
module bitreset_pwm_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [1:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       pwm_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    bitreset_pwm uut (
        .clk(clk), .rst(rst), .tick(tick), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .pwm_out(pwm_out)
    );

    typedef struct packed {
        logic [1:0] pre;
        logic [6:0] duty;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 7'd64,  4'd4},  // R4 half duty, longest period
        '{2'd1, 7'd10,  4'd4},  // R4
        '{2'd2, 7'd31,  4'd4},  // R4 one below period
        '{2'd3, 7'd5,   4'd4},  // R4
        '{2'd3, 7'd0,   4'd4},  // R4 zero duty
        '{2'd1, 7'd64,  4'd5},  // R5 duty equals period
        '{2'd3, 7'd100, 4'd5},  // R5 duty above period
        '{2'd2, 7'd32,  4'd5},  // R5
        '{2'd0, 7'd127, 4'd6}   // R6 one low tick per 128
    };

    task automatic check(input string req, input int got, input int exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; d = rd_data;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1", int'(pwm_out), 0);
        rd(2'd0, v); check("R1", int'(v), 8'h00);
        rd(2'd1, v); check("R1", int'(v), 8'h00);

        // R2 readback with unused bits and spare addresses
        wr(2'd1, 8'hFF); rd(2'd1, v); check("R2", int'(v), 8'h7F);
        wr(2'd0, 8'h7E); rd(2'd0, v); check("R2", int'(v), 8'h02);
        wr(2'd2, 8'hFF); rd(2'd2, v); check("R2", int'(v), 8'h00);
        wr(2'd3, 8'hFF); rd(2'd3, v); check("R2", int'(v), 8'h00);
        rd(2'd0, v); check("R2", int'(v), 8'h02);
        rd(2'd1, v); check("R2", int'(v), 8'h7F);

        // R3 disabled: output low even with full duty and ticks
        ticks(5);
        check("R3", int'(pwm_out), 0);

        // Table walk: per-tick waveform against (k mod P) < duty
        for (int n = 0; n < NV; n++) begin
            int per;
            int mism;
            per  = 1 << (7 - int'(VECS[n].pre));
            mism = 0;
            wr(2'd0, 8'h00);
            wr(2'd1, {1'b0, VECS[n].duty});
            wr(2'd0, {1'b1, 5'b0, VECS[n].pre});
            for (int k = 0; k < 2 * per; k++) begin
                int e;
                e = ((k % per) < int'(VECS[n].duty)) ? 1 : 0;
                if (int'(pwm_out) != e) mism++;
                ticks(1);
            end
            check($sformatf("R%0d vec%0d", VECS[n].req, n), mism, 0);
        end

        // R3 counter held at zero while disabled
        wr(2'd0, 8'h00); wr(2'd1, 8'd3);
        wr(2'd0, 8'h83); ticks(10);
        check("R3", int'(pwm_out), 0);
        wr(2'd0, 8'h03); ticks(4);
        wr(2'd0, 8'h83);
        check("R3", int'(pwm_out), 1);

        // R7 prescaler change keeps count: 40 under p0, switch to p3
        wr(2'd0, 8'h00); wr(2'd1, 8'd10);
        wr(2'd0, 8'h80); ticks(40);
        wr(2'd0, 8'h83);
        check("R7", int'(pwm_out), 1);  // low bits 8 < 10
        ticks(3);
        check("R7", int'(pwm_out), 0);  // count 43, low bits 11
        ticks(4);
        check("R7", int'(pwm_out), 0);  // count 47, low bits 15
        ticks(1);
        check("R7", int'(pwm_out), 1);  // wrapped to 0

        // R8 duty change mid-period
        wr(2'd0, 8'h00); wr(2'd1, 8'd8);
        wr(2'd0, 8'h83); ticks(5);
        check("R8", int'(pwm_out), 1);
        wr(2'd1, 8'd4);
        check("R8", int'(pwm_out), 0);
        wr(2'd1, 8'd6);
        check("R8", int'(pwm_out), 1);

        // R9 no advance without tick
        wr(2'd0, 8'h00); wr(2'd1, 8'd3);
        wr(2'd0, 8'h83); ticks(2);
        repeat (20) @(negedge clk);
        check("R9", int'(pwm_out), 1);
        ticks(1);
        check("R9", int'(pwm_out), 0);

        // R1 reset mid-run clears everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1", int'(pwm_out), 0);
        rd(2'd0, v); check("R1", int'(v), 8'h00);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule